// File: doc/BRIEF.md
# Configurable UART Transmitter with RS485 Driver Enable

This block takes bytes from a valid/ready stream, holds them in a transmit FIFO, and shifts them out one character at a time on a serial line. A pulse from an outside baud generator marks each bit period. Software sets the character format at run time. The data length can be 7 or 8 bits, the frame can end with one or two stop bits, and the parity slot can be none, odd, even, constant-one or constant-zero. The block reads the format once, when a character starts. A change in the middle of a character therefore affects only the characters that follow it.

An enable output drives the direction input of an RS485 line driver. It goes high on the same baud tick as the start bit, with no outside delay circuit. It stays high until the last stop bit has finished. It is also high while the line is held in a break. A break request holds the serial line low. If a character is already on the line, that character completes before the break begins. No new character starts while the break request is held.

Top module: `uart_txf_top`

## Requirements
- R1: After reset, `txd` is 1, `txden` is 0, `busy` is 0 and `in_ready` is 1.
- R2: A byte is stored when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is low exactly when DEPTH bytes are stored. A byte offered while `in_ready` is low is dropped. Bytes go out in the order they were accepted.
- R3: A character is one low start bit, then the data bits least significant first: 7 bits (bits 6..0) when `cfg_len8`=0, or 8 bits when `cfg_len8`=1. While the line is idle, `txd` is 1 and `txden` is 0.
- R4: `cfg_parity` selects the parity slot that follows the data bits. 0 = no slot. 1 = odd: the data and parity ones together make an odd count. 2 = even: they make an even count. 3 = constant 1. 4 = constant 0. Codes 5 to 7 act as 0.
- R5: After the parity slot, the character has one stop bit (1) when `cfg_stop2`=0, or two when `cfg_stop2`=1.
- R6: Each `baud_tick` moves the line on by one bit. `txd` and `txden` change only on the clock edge that samples a `baud_tick`.
- R7: `txden` rises on the tick that drives the start bit. It stays high through the data, parity and stop bits. It falls on the tick that ends the last stop bit, unless that same tick starts another character or a break.
- R8: A tick that finds `brk_req` high and no character in progress drives `txd` low and `txden` high. No character starts while `brk_req` stays high. A character already in progress finishes first. The first tick after `brk_req` falls either starts the next queued character or returns the line to idle.
- R9: Data length, stop count and parity mode are read on the tick that starts a character. Changes made later do not alter that character.
- R10: `busy` is 1 while the FIFO holds a byte, a character is on the line, or a break is held. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 8 | Byte to queue |
| in_valid | input | 1 | `in_data` is offered |
| in_ready | output | 1 | FIFO has room |
| baud_tick | input | 1 | One-clock pulse per bit period |
| cfg_len8 | input | 1 | 1 = 8 data bits, 0 = 7 |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| cfg_parity | input | 3 | Parity mode code (see R4) |
| brk_req | input | 1 | Hold the line in break |
| txd | output | 1 | Serial data out |
| txden | output | 1 | RS485 driver enable |
| busy | output | 1 | FIFO not empty or line active |

## Verification
The assertions check four properties on every cycle. First, a low line always has the driver enable high. Second, the idle state has the line high and the enable low, and the break state holds the line low. Third, `txd` and `txden` change only after a tick. Fourth, the FIFO count stays in range and moves correctly on each push. Other behaviours need a model of whole characters, so only the bench scenarios can show them. These are the bit order, parity values for each mode, stop-bit count, reading the format only at character start, the point where a break begins after a character in progress, dropping bytes offered to a full FIFO, and the exact tick where the enable falls.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

   localparam int DATA_W    = 8;
   localparam int FRAME_MAX = 1 + DATA_W + 1 + 2;
   localparam int SLOT_W    = $clog2(FRAME_MAX + 1);

   typedef enum logic [2:0] {
      PAR_NONE  = 3'd0,
      PAR_ODD   = 3'd1,
      PAR_EVEN  = 3'd2,
      PAR_MARK  = 3'd3,
      PAR_SPACE = 3'd4
   } par_mode_e;

   typedef struct packed {
      logic [FRAME_MAX-1:0] bits;   // LSB goes on the line first
      logic [SLOT_W-1:0]    slots;  // number of bit periods in the character
   } frame_t;

   function automatic frame_t make_frame(input logic [DATA_W-1:0] d,
                                         input logic len8,
                                         input logic stop2,
                                         input logic [2:0] pmode);
      frame_t f;
      int     n;
      logic   ones_par;
      logic   pbit;
      logic   has_p;
      f.bits   = '1;
      n        = 0;
      f.bits[n] = 1'b0;
      n++;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < DATA_W - 1 || len8) begin
            f.bits[n] = d[i];
            n++;
         end
      end
      ones_par = len8 ? ^d : ^d[DATA_W-2:0];
      has_p    = 1'b1;
      pbit     = 1'b0;
      case (pmode)
         PAR_ODD:   pbit = ~ones_par;
         PAR_EVEN:  pbit = ones_par;
         PAR_MARK:  pbit = 1'b1;
         PAR_SPACE: pbit = 1'b0;
         default:   has_p = 1'b0;
      endcase
      if (has_p) begin
         f.bits[n] = pbit;
         n++;
      end
      n = n + (stop2 ? 2 : 1);
      f.slots = SLOT_W'(n);
      return f;
   endfunction

endpackage

// File: rtl/uart_txf_fifo.sv
module uart_txf_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 128
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   initial begin
      if (DEPTH < 2 || (1 << AW) != DEPTH)
         $error("uart_txf_fifo: DEPTH must be a power of two and at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
   assign rdata = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |=> (count == $past(count) + 1'b1));
   a_r2_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/uart_txf_ser.sv
module uart_txf_ser
   import uart_txf_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              brk_req,
   input  logic              cfg_len8,
   input  logic              cfg_stop2,
   input  logic [2:0]        cfg_parity,
   input  logic              src_empty,
   input  logic [DATA_W-1:0] src_data,
   output logic              pop,
   output logic              txd,
   output logic              txden,
   output logic              active
);
   typedef enum logic [1:0] {S_IDLE, S_SEND, S_BRK} ser_state_e;

   ser_state_e           st;
   logic [FRAME_MAX-1:0] sh;
   logic [SLOT_W-1:0]    left;
   logic                 boundary;
   frame_t               nf;

   always_comb begin
      nf       = make_frame(src_data, cfg_len8, cfg_stop2, cfg_parity);
      boundary = tick && (st != S_SEND || left == '0);
      pop      = boundary && !brk_req && !src_empty;
   end

   assign active = (st != S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= S_IDLE;
         txd   <= 1'b1;
         txden <= 1'b0;
         sh    <= '1;
         left  <= '0;
      end else if (tick) begin
         if (st == S_SEND && left != '0) begin
            txd  <= sh[0];
            sh   <= {1'b1, sh[FRAME_MAX-1:1]};
            left <= left - 1'b1;
         end else if (brk_req) begin
            st    <= S_BRK;
            txd   <= 1'b0;
            txden <= 1'b1;
         end else if (!src_empty) begin
            st    <= S_SEND;
            txd   <= nf.bits[0];
            sh    <= {1'b1, nf.bits[FRAME_MAX-1:1]};
            left  <= nf.slots - 1'b1;
            txden <= 1'b1;
         end else begin
            st    <= S_IDLE;
            txd   <= 1'b1;
            txden <= 1'b0;
         end
      end
   end

   a_r3_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE) |-> (txd && !txden));
   a_r7_low_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !txd |-> txden);
   a_r8_break_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_BRK) |-> (!txd && txden));
   a_r6_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(txd) && $stable(txden)));

endmodule

// File: rtl/uart_txf_top.sv
module uart_txf_top
   import uart_txf_pkg::*;
#(
   parameter int DEPTH = 128
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  in_data,
   input  logic        in_valid,
   output logic        in_ready,
   input  logic        baud_tick,
   input  logic        cfg_len8,
   input  logic        cfg_stop2,
   input  logic [2:0]  cfg_parity,
   input  logic        brk_req,
   output logic        txd,
   output logic        txden,
   output logic        busy
);
   initial begin
      if (DATA_W != 8) $error("uart_txf_top: byte-wide data path expected");
   end

   logic              f_full, f_empty, f_pop, f_push, s_active;
   logic [DATA_W-1:0] f_rdata;

   assign f_push   = in_valid && !f_full;
   assign in_ready = !f_full;
   assign busy     = s_active || !f_empty;

   uart_txf_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (f_push),
      .wdata (in_data),
      .pop   (f_pop),
      .rdata (f_rdata),
      .full  (f_full),
      .empty (f_empty)
   );

   uart_txf_ser u_ser (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (baud_tick),
      .brk_req    (brk_req),
      .cfg_len8   (cfg_len8),
      .cfg_stop2  (cfg_stop2),
      .cfg_parity (cfg_parity),
      .src_empty  (f_empty),
      .src_data   (f_rdata),
      .pop        (f_pop),
      .txd        (txd),
      .txden      (txden),
      .active     (s_active)
   );

   a_r10_busy_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy) |-> (txd && !txden && in_ready));

endmodule

// File: tb/uart_txf_top_tb.sv
`timescale 1ns/1ps
module uart_txf_top_tb;
   localparam int DEPTH = 128;

   logic       clk = 0, rst_n = 0;
   logic [7:0] in_data = 0;
   logic       in_valid = 0, baud_tick = 0;
   logic       cfg_len8 = 1, cfg_stop2 = 0, brk_req = 0;
   logic [2:0] cfg_parity = 0;
   logic       in_ready, txd, txden, busy;

   int compared = 0, mismatched = 0;
   int tick_per = 3;
   bit tick_en = 1, run_cmp = 0, done = 0;
   string cur_req = "R1";

   uart_txf_top #(.DEPTH(DEPTH)) u_dut (.*);

   always #5 clk = ~clk;

   // behavioural reference: queue of bytes, queue of pending line bits
   byte unsigned mq[$];
   bit  mbits[$];
   int  m_state = 0;           // 0 idle, 1 character, 2 break
   bit  m_txd = 1, m_txden = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete(); mbits.delete();
         m_state = 0; m_txd = 1; m_txden = 0;
      end else begin
         bit do_push, had;
         do_push = in_valid && (mq.size() < DEPTH);
         had = (mq.size() > 0);
         if (baud_tick) begin
            if (m_state == 1 && mbits.size() > 0) m_txd = mbits.pop_front();
            else if (brk_req) begin m_state = 2; m_txd = 0; m_txden = 1; end
            else if (had) begin
               byte unsigned b;
               int nd, ones;
               b = mq.pop_front();
               nd = cfg_len8 ? 8 : 7;
               ones = 0;
               for (int i = 0; i < nd; i++) begin mbits.push_back(b[i]); ones += b[i]; end
               case (cfg_parity)
                  3'd1: mbits.push_back((ones % 2) == 0);
                  3'd2: mbits.push_back((ones % 2) == 1);
                  3'd3: mbits.push_back(1'b1);
                  3'd4: mbits.push_back(1'b0);
                  default: ;
               endcase
               mbits.push_back(1'b1);
               if (cfg_stop2) mbits.push_back(1'b1);
               m_state = 1; m_txd = 0; m_txden = 1;
            end else begin m_state = 0; m_txd = 1; m_txden = 0; end
         end
         if (do_push) mq.push_back(in_data);
      end
   end

   task automatic chk(string req, string what, logic act, logic exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (run_cmp && rst_n) begin
         chk(cur_req, "txd", txd, m_txd);
         chk("R7", "txden", txden, m_txden);
         chk("R10", "busy", busy, (mq.size() > 0) || (m_state != 0));
         chk("R2", "in_ready", in_ready, mq.size() < DEPTH);
      end
   end

   initial begin : tickgen
      int cnt = 0;
      forever begin
         @(negedge clk);
         if (tick_en && cnt >= tick_per - 1) begin baud_tick = 1; cnt = 0; end
         else begin baud_tick = 0; if (tick_en) cnt++; end
      end
   end

   task automatic send(input byte unsigned b);
      @(negedge clk); in_data = b; in_valid = 1;
      while (!in_ready) @(negedge clk);
      @(negedge clk); in_valid = 0;
   endtask

   task automatic wait_idle();
      while (m_state != 0 || mq.size() != 0) @(negedge clk);
      repeat (tick_per * 2 + 2) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "txd", txd, 1); chk("R1", "txden", txden, 0);
      chk("R1", "busy", busy, 0); chk("R1", "in_ready", in_ready, 1);
      rst_n = 1;
      run_cmp = 1;

      // R3: 8N1 frames, R6 with ticks every 3 clocks
      cur_req = "R3";
      send(8'hA5); send(8'h01); send(8'h80);
      wait_idle();

      // R4 / R5: every parity code, 7 and 8 bits, two stop bits
      cur_req = "R4";
      for (int p = 0; p < 8; p++) begin
         cfg_parity = 3'(p);
         cfg_len8 = p[0];
         cfg_stop2 = p[1];
         send(8'hD3); send(8'h6C);
         wait_idle();
      end

      // R6: tick every clock, then slow ticks
      cur_req = "R6";
      cfg_parity = 2; cfg_len8 = 1; cfg_stop2 = 1; tick_per = 1;
      send(8'h3C); send(8'hF0);
      wait_idle();
      tick_per = 5;
      send(8'h5A);
      wait_idle();

      // R9: format changed in mid-character
      cur_req = "R9";
      tick_per = 4; cfg_parity = 1; cfg_len8 = 1; cfg_stop2 = 0;
      send(8'h77); send(8'h12);
      repeat (10) @(negedge clk);
      cfg_parity = 3; cfg_len8 = 0; cfg_stop2 = 1;
      wait_idle();

      // R8: break raised mid-character, bytes queued behind it
      cur_req = "R8";
      send(8'hC3); send(8'h3C);
      repeat (6) @(negedge clk);
      brk_req = 1;
      repeat (120) @(negedge clk);
      brk_req = 0;
      wait_idle();
      // break from idle
      @(negedge clk); brk_req = 1;
      repeat (30) @(negedge clk);
      brk_req = 0;
      wait_idle();

      // R2: fill FIFO with ticks stopped, offer extra bytes, then drain
      cur_req = "R2";
      tick_en = 0; tick_per = 2; cfg_parity = 0; cfg_len8 = 1; cfg_stop2 = 0;
      @(negedge clk);
      for (int i = 0; i < DEPTH + 4; i++) begin
         in_data = 8'(i * 7 + 1); in_valid = 1;
         @(negedge clk);
      end
      in_valid = 0;
      chk("R2", "in_ready when full", in_ready, 0);
      chk("R10", "busy when full", busy, 1);
      tick_en = 1;
      wait_idle();
      chk("R10", "busy after drain", busy, 0);

      finish_run();
   end
endmodule